// File: doc/BRIEF.md
# Delayed Cache Request Queue

This block sits between a processor's load/store path and a data cache. Each memory request is enqueued together with a launch delay. The delay is counted down one cycle at a time. When it reaches zero the request is offered to the cache. The entry then stays in the queue until the cache shows that the request is finished.

A load is finished when one of two cache pipeline result buffers presents data for the same address and request number. The block then writes the data back to a register. A flush is finished when one of the two pipelines reports that flush as done. Any other request is finished as soon as it has been offered. Finished entries leave the queue, and the younger entries move down to close the gap.

The queue holds eight entries by default. A full flag tells the producer to hold off.

Top module: `dcache_req_queue`

## Requirements
- R1: After reset the queue is empty: `full`, `sub_valid`, `done_valid`, `wb_valid` and `size_err` are all low.
- R2: An entry enqueued at clock edge t with delay d is offered on `sub_valid` in the cycle that follows edge t+d. At most one entry is offered per cycle, and the oldest eligible entry goes first. `sub_addr` and `sub_reqno` carry that entry's fields.
- R3: An entry is never reported complete while its delay is nonzero or before it has been offered, even when a cache buffer already matches it.
- R4: A load (`enq_kind` 0) completes when result buffer 0 or buffer 1 is valid with an equal address and request number. If both match, the data comes from buffer 0.
- R5: A flush (`enq_kind` 1) completes when either pipeline's flush-done report is valid with an equal address and request number.
- R6: A request of any other kind (`enq_kind` 2 or 3) completes in the first cycle after the cycle in which it was offered, provided no older entry completes in that cycle.
- R7: For a load with a byte count of 1, 2, 4, 8 or 16, completion sets `wb_valid`, `wb_reg` and `wb_fp`. `wb_data` holds the low byte-count bytes of the selected buffer, and the upper bytes are zero.
- R8: A load with any other byte count completes with `size_err` high and `wb_valid` low.
- R9: At most one entry completes per cycle, and it is the oldest complete one. The remaining entries keep their order.
- R10: `full` is high exactly when the queue holds eight entries. An enqueue while `full` is high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Enqueue strobe |
| enq_kind | input | 2 | 0 load, 1 flush, 2/3 other |
| enq_addr | input | 32 | Request address |
| enq_reqno | input | 8 | Request number |
| enq_reg | input | 6 | Destination register index |
| enq_fp | input | 1 | Destination class: 1 floating, 0 general |
| enq_size | input | 5 | Access size in bytes |
| enq_delay | input | 6 | Cycles to wait before the request is offered |
| full | output | 1 | Queue holds the maximum number of entries |
| sub_valid | output | 1 | A request is offered to the cache |
| sub_kind | output | 2 | Kind of the offered request |
| sub_addr | output | 32 | Address of the offered request |
| sub_reqno | output | 8 | Request number of the offered request |
| rb_valid0 | input | 1 | Result buffer 0 holds data |
| rb_addr0 | input | 32 | Result buffer 0 address |
| rb_reqno0 | input | 8 | Result buffer 0 request number |
| rb_data0 | input | 128 | Result buffer 0 data |
| rb_valid1 | input | 1 | Result buffer 1 holds data |
| rb_addr1 | input | 32 | Result buffer 1 address |
| rb_reqno1 | input | 8 | Result buffer 1 request number |
| rb_data1 | input | 128 | Result buffer 1 data |
| fd_valid0 | input | 1 | Pipeline 0 flush done |
| fd_addr0 | input | 32 | Pipeline 0 flushed address |
| fd_reqno0 | input | 8 | Pipeline 0 flush request number |
| fd_valid1 | input | 1 | Pipeline 1 flush done |
| fd_addr1 | input | 32 | Pipeline 1 flushed address |
| fd_reqno1 | input | 8 | Pipeline 1 flush request number |
| done_valid | output | 1 | An entry completes this cycle |
| done_kind | output | 2 | Kind of the completing entry |
| done_reqno | output | 8 | Request number of the completing entry |
| wb_valid | output | 1 | Register writeback |
| wb_reg | output | 6 | Writeback register index |
| wb_fp | output | 1 | Writeback register class |
| wb_data | output | 128 | Writeback data, zero above the access size |
| size_err | output | 1 | Completing load has an illegal size |

## Verification
The bench builds the block with its default parameters: eight entries, 32-bit addresses, 8-bit request numbers and a 6-bit delay. With eight entries the full condition and a dropped enqueue are quick to reach. The random traffic uses only four addresses and four request numbers. This makes buffers match several entries at once, so oldest-first completion, compaction and the buffer-0 preference are exercised often. Delays stay below eleven, so entries are offered while older entries are still waiting for their data.

// File: rtl/dcache_req_queue.sv
module dcache_req_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int QW    = 8,
  parameter int RIW   = 6,
  parameter int CW    = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enq_valid,
  input  logic [1:0]     enq_kind,
  input  logic [AW-1:0]  enq_addr,
  input  logic [QW-1:0]  enq_reqno,
  input  logic [RIW-1:0] enq_reg,
  input  logic           enq_fp,
  input  logic [4:0]     enq_size,
  input  logic [CW-1:0]  enq_delay,
  output logic           full,
  output logic           sub_valid,
  output logic [1:0]     sub_kind,
  output logic [AW-1:0]  sub_addr,
  output logic [QW-1:0]  sub_reqno,
  input  logic           rb_valid0,
  input  logic [AW-1:0]  rb_addr0,
  input  logic [QW-1:0]  rb_reqno0,
  input  logic [127:0]   rb_data0,
  input  logic           rb_valid1,
  input  logic [AW-1:0]  rb_addr1,
  input  logic [QW-1:0]  rb_reqno1,
  input  logic [127:0]   rb_data1,
  input  logic           fd_valid0,
  input  logic [AW-1:0]  fd_addr0,
  input  logic [QW-1:0]  fd_reqno0,
  input  logic           fd_valid1,
  input  logic [AW-1:0]  fd_addr1,
  input  logic [QW-1:0]  fd_reqno1,
  output logic           done_valid,
  output logic [1:0]     done_kind,
  output logic [QW-1:0]  done_reqno,
  output logic           wb_valid,
  output logic [RIW-1:0] wb_reg,
  output logic           wb_fp,
  output logic [127:0]   wb_data,
  output logic           size_err
);
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW   = $clog2(DEPTH + 1);
  localparam logic [1:0] K_LOAD  = 2'd0;
  localparam logic [1:0] K_FLUSH = 2'd1;

  logic [1:0]     q_kind  [DEPTH];
  logic [AW-1:0]  q_addr  [DEPTH];
  logic [QW-1:0]  q_reqno [DEPTH];
  logic [RIW-1:0] q_reg   [DEPTH];
  logic           q_fp    [DEPTH];
  logic [4:0]     q_size  [DEPTH];
  logic [CW-1:0]  q_cnt   [DEPTH];
  logic           q_sent  [DEPTH];
  logic [NW-1:0]  count;

  logic          sub_hit, done_hit, done_use0, enq_fire, legal;
  logic [IW-1:0] sub_idx, done_idx;
  logic [IW-1:0] src [DEPTH];
  logic [NW-1:0] tail;
  logic [127:0]  sel;

  assign full     = (count == NW'(DEPTH));
  assign enq_fire = enq_valid && !full;
  assign tail     = count - NW'(done_hit);

  always_comb begin
    sub_hit = 1'b0;
    sub_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (i < int'(count) && q_cnt[i] == '0 && !q_sent[i]) begin
        sub_hit = 1'b1;
        sub_idx = IW'(i);
      end
  end

  always_comb begin
    logic m0, m1, f0, f1, ok;
    done_hit  = 1'b0;
    done_idx  = '0;
    done_use0 = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      m0 = rb_valid0 && rb_addr0 == q_addr[i] && rb_reqno0 == q_reqno[i];
      m1 = rb_valid1 && rb_addr1 == q_addr[i] && rb_reqno1 == q_reqno[i];
      f0 = fd_valid0 && fd_addr0 == q_addr[i] && fd_reqno0 == q_reqno[i];
      f1 = fd_valid1 && fd_addr1 == q_addr[i] && fd_reqno1 == q_reqno[i];
      if (q_kind[i] == K_LOAD)       ok = m0 || m1;
      else if (q_kind[i] == K_FLUSH) ok = f0 || f1;
      else                           ok = 1'b1;
      if (i < int'(count) && q_cnt[i] == '0 && q_sent[i] && ok) begin
        done_hit  = 1'b1;
        done_idx  = IW'(i);
        done_use0 = m0;
      end
    end
  end

  always_comb
    for (int i = 0; i < DEPTH; i++)
      src[i] = (done_hit && IW'(i) >= done_idx && i < DEPTH - 1) ? IW'(i + 1) : IW'(i);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        q_cnt[i]  <= '0;
        q_sent[i] <= 1'b0;
      end
    end else begin
      count <= count + NW'(enq_fire) - NW'(done_hit);
      for (int i = 0; i < DEPTH; i++)
        if (enq_fire && NW'(i) == tail) begin
          q_cnt[i]  <= enq_delay;
          q_sent[i] <= 1'b0;
        end else begin
          q_cnt[i]  <= (q_cnt[src[i]] != '0) ? q_cnt[src[i]] - 1'b1 : '0;
          q_sent[i] <= q_sent[src[i]] || (sub_hit && src[i] == sub_idx);
        end
    end

  always_ff @(posedge clk)
    for (int i = 0; i < DEPTH; i++)
      if (enq_fire && NW'(i) == tail) begin
        q_kind[i]  <= enq_kind;
        q_addr[i]  <= enq_addr;
        q_reqno[i] <= enq_reqno;
        q_reg[i]   <= enq_reg;
        q_fp[i]    <= enq_fp;
        q_size[i]  <= enq_size;
      end else begin
        q_kind[i]  <= q_kind[src[i]];
        q_addr[i]  <= q_addr[src[i]];
        q_reqno[i] <= q_reqno[src[i]];
        q_reg[i]   <= q_reg[src[i]];
        q_fp[i]    <= q_fp[src[i]];
        q_size[i]  <= q_size[src[i]];
      end

  assign sub_valid  = sub_hit;
  assign sub_kind   = q_kind[sub_idx];
  assign sub_addr   = q_addr[sub_idx];
  assign sub_reqno  = q_reqno[sub_idx];

  assign done_valid = done_hit;
  assign done_kind  = q_kind[done_idx];
  assign done_reqno = q_reqno[done_idx];
  assign wb_reg     = q_reg[done_idx];
  assign wb_fp      = q_fp[done_idx];
  assign legal      = q_size[done_idx] inside {5'd1, 5'd2, 5'd4, 5'd8, 5'd16};
  assign wb_valid   = done_hit && done_kind == K_LOAD && legal;
  assign size_err   = done_hit && done_kind == K_LOAD && !legal;
  assign sel        = done_use0 ? rb_data0 : rb_data1;

  always_comb
    for (int b = 0; b < 16; b++)
      wb_data[8*b +: 8] = (b < int'(q_size[done_idx])) ? sel[8*b +: 8] : 8'h00;

  p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    count == $past(count) + NW'($past(enq_fire)) - NW'($past(done_hit)));
  p_full_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    full && !done_valid |=> full);
  p_wb_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done_valid && done_kind == K_LOAD && !size_err);
  p_size_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> done_valid && !wb_valid);
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= NW'(DEPTH));
endmodule

// File: tb/tb_dcache_req_queue.sv
`timescale 1ns/1ps
module tb_dcache_req_queue;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic enq_valid; logic [1:0] enq_kind; logic [31:0] enq_addr; logic [7:0] enq_reqno;
  logic [5:0] enq_reg; logic enq_fp; logic [4:0] enq_size; logic [5:0] enq_delay;
  logic full, sub_valid; logic [1:0] sub_kind; logic [31:0] sub_addr; logic [7:0] sub_reqno;
  logic rb_valid0, rb_valid1, fd_valid0, fd_valid1;
  logic [31:0] rb_addr0, rb_addr1, fd_addr0, fd_addr1;
  logic [7:0] rb_reqno0, rb_reqno1, fd_reqno0, fd_reqno1;
  logic [127:0] rb_data0, rb_data1;
  logic done_valid; logic [1:0] done_kind; logic [7:0] done_reqno;
  logic wb_valid; logic [5:0] wb_reg; logic wb_fp; logic [127:0] wb_data; logic size_err;

  dcache_req_queue dut (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  int mn = 0;
  logic [1:0] mk[8]; logic [31:0] ma[8]; logic [7:0] mq[8]; logic [5:0] mr[8];
  logic mf[8]; logic [4:0] ms[8]; int mc[8]; bit mse[8];
  int e_sub, e_done;
  logic o_done, o_sub, o_wb, o_err; logic [7:0] o_reqno; logic [127:0] o_data;

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit m0(int i);
    return rb_valid0 && rb_addr0 == ma[i] && rb_reqno0 == mq[i];
  endfunction
  function automatic bit m1(int i);
    return rb_valid1 && rb_addr1 == ma[i] && rb_reqno1 == mq[i];
  endfunction
  function automatic bit fin(int i);
    if (mk[i] == 2'd0) return m0(i) || m1(i);
    if (mk[i] == 2'd1) return (fd_valid0 && fd_addr0 == ma[i] && fd_reqno0 == mq[i]) ||
                              (fd_valid1 && fd_addr1 == ma[i] && fd_reqno1 == mq[i]);
    return 1;
  endfunction
  function automatic bit legal(logic [4:0] s);
    return s == 1 || s == 2 || s == 4 || s == 8 || s == 16;
  endfunction
  function automatic logic [127:0] exp_data(int i);
    logic [127:0] s, r;
    s = m0(i) ? rb_data0 : rb_data1;
    r = '0;
    for (int b = 0; b < 16; b++) if (b < int'(ms[i])) r[8*b +: 8] = s[8*b +: 8];
    return r;
  endfunction

  task automatic idle();
    enq_valid = 0; enq_kind = 0; enq_addr = 0; enq_reqno = 0; enq_reg = 0; enq_fp = 0;
    enq_size = 4; enq_delay = 0;
    rb_valid0 = 0; rb_addr0 = 0; rb_reqno0 = 0; rb_data0 = 0;
    rb_valid1 = 0; rb_addr1 = 0; rb_reqno1 = 0; rb_data1 = 0;
    fd_valid0 = 0; fd_addr0 = 0; fd_reqno0 = 0;
    fd_valid1 = 0; fd_addr1 = 0; fd_reqno1 = 0;
  endtask

  task automatic enq(logic [1:0] k, logic [31:0] a, logic [7:0] q, logic [4:0] s, logic [5:0] d);
    enq_valid = 1; enq_kind = k; enq_addr = a; enq_reqno = q; enq_size = s; enq_delay = d;
    enq_reg = q[5:0]; enq_fp = q[0];
  endtask

  task automatic run_cycle();
    int pre;
    @(negedge clk); #1;
    e_sub = -1; e_done = -1;
    for (int i = mn - 1; i >= 0; i--) if (mc[i] == 0 && !mse[i]) e_sub = i;
    for (int i = mn - 1; i >= 0; i--) if (mc[i] == 0 && mse[i] && fin(i)) e_done = i;
    o_done = done_valid; o_sub = sub_valid; o_wb = wb_valid; o_err = size_err;
    o_reqno = done_reqno; o_data = wb_data;
    chk(full == (mn == 8), "R10 full", full, mn == 8);
    chk(sub_valid == (e_sub >= 0), "R2 sub_valid", sub_valid, e_sub >= 0);
    if (e_sub >= 0 && sub_valid) begin
      chk(sub_addr == ma[e_sub], "R2 sub_addr", sub_addr, ma[e_sub]);
      chk(sub_reqno == mq[e_sub], "R2 sub_reqno", sub_reqno, mq[e_sub]);
    end
    chk(done_valid == (e_done >= 0), "R9 done_valid", done_valid, e_done >= 0);
    if (e_done >= 0 && done_valid) begin
      chk(done_reqno == mq[e_done], "R9 done_reqno", done_reqno, mq[e_done]);
      if (mk[e_done] == 2'd0 && legal(ms[e_done])) begin
        chk(wb_valid, "R7 wb_valid", wb_valid, 1);
        chk(wb_data == exp_data(e_done), "R7 wb_data", wb_data, exp_data(e_done));
        chk(wb_reg == mr[e_done] && wb_fp == mf[e_done], "R7 wb_dest",
            {wb_fp, wb_reg}, {mf[e_done], mr[e_done]});
      end else if (mk[e_done] == 2'd0) begin
        chk(size_err && !wb_valid, "R8 size_err", {size_err, wb_valid}, 2'b10);
      end else begin
        chk(!wb_valid && !size_err, "R7 no_wb", {size_err, wb_valid}, 2'b00);
      end
    end else begin
      chk(!wb_valid && !size_err, "R7 idle_wb", {size_err, wb_valid}, 2'b00);
    end
    @(posedge clk); #1;
    pre = mn;
    if (e_done >= 0) begin
      for (int i = e_done; i < mn - 1; i++) begin
        mk[i] = mk[i+1]; ma[i] = ma[i+1]; mq[i] = mq[i+1]; mr[i] = mr[i+1];
        mf[i] = mf[i+1]; ms[i] = ms[i+1]; mc[i] = mc[i+1]; mse[i] = mse[i+1];
      end
      mn--;
      if (e_sub > e_done) e_sub--;
    end
    if (e_sub >= 0) mse[e_sub] = 1;
    for (int i = 0; i < mn; i++) if (mc[i] > 0) mc[i]--;
    if (enq_valid && pre < 8) begin
      mk[mn] = enq_kind; ma[mn] = enq_addr; mq[mn] = enq_reqno; mr[mn] = enq_reg;
      mf[mn] = enq_fp; ms[mn] = enq_size; mc[mn] = int'(enq_delay); mse[mn] = 0;
      mn++;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    idle();
    repeat (3) @(posedge clk);
    #1;
    chk(!full && !sub_valid && !done_valid && !wb_valid && !size_err, "R1 reset",
        {full, sub_valid, done_valid, wb_valid, size_err}, 0);
    rst_n = 1;
    @(posedge clk); #1;

    // R3/R2: buffer matches from the start, delay 3 -> complete on 5th cycle
    enq(0, 32'h200, 8'd9, 5'd4, 6'd3);
    rb_valid0 = 1; rb_addr0 = 32'h200; rb_reqno0 = 9; rb_data0 = {4{32'hA5A5_1234}};
    run_cycle();
    enq_valid = 0;
    for (int k = 1; k <= 5; k++) begin
      run_cycle();
      if (k < 5) chk(!o_done, "R3 early completion", o_done, 0);
      if (k == 4) chk(o_sub, "R2 submit after delay", o_sub, 1);
      if (k == 5) begin
        chk(o_done && o_wb, "R2 completion cycle", {o_done, o_wb}, 2'b11);
        chk(o_data == 128'hA5A5_1234, "R7 size 4 data", o_data, 128'hA5A5_1234);
      end
    end

    // R4: both buffers match -> buffer 0 data
    idle();
    enq(0, 32'h300, 8'd1, 5'd16, 6'd0);
    rb_valid0 = 1; rb_addr0 = 32'h300; rb_reqno0 = 1; rb_data0 = {4{32'h1111_0000}};
    rb_valid1 = 1; rb_addr1 = 32'h300; rb_reqno1 = 1; rb_data1 = {4{32'h2222_0000}};
    run_cycle(); enq_valid = 0;
    run_cycle(); run_cycle();
    chk(o_wb && o_data == {4{32'h1111_0000}}, "R4 buffer0 first", o_data, {4{32'h1111_0000}});

    // R4: only buffer 1 matches, size 8
    idle();
    enq(0, 32'h340, 8'd2, 5'd8, 6'd0);
    rb_valid1 = 1; rb_addr1 = 32'h340; rb_reqno1 = 2; rb_data1 = {4{32'hCAFE_F00D}};
    rb_valid0 = 1; rb_addr0 = 32'h340; rb_reqno0 = 3;
    run_cycle(); enq_valid = 0;
    run_cycle(); run_cycle();
    chk(o_wb && o_data == {2{32'hCAFE_F00D}}, "R4 buffer1", o_data, {2{32'hCAFE_F00D}});

    // R5: flush done on pipeline 1
    idle();
    enq(1, 32'h400, 8'd7, 5'd4, 6'd0);
    fd_valid1 = 1; fd_addr1 = 32'h400; fd_reqno1 = 7;
    run_cycle(); enq_valid = 0;
    run_cycle(); run_cycle();
    chk(o_done && o_reqno == 7 && !o_wb, "R5 flush done", {o_done, o_reqno}, {1'b1, 8'd7});

    // R6: other kind completes right after submission
    idle();
    enq(2, 32'h500, 8'd12, 5'd4, 6'd2);
    run_cycle(); enq_valid = 0;
    for (int k = 1; k <= 4; k++) begin
      run_cycle();
      if (k == 3) chk(o_sub && !o_done, "R6 submit cycle", {o_sub, o_done}, 2'b10);
      if (k == 4) chk(o_done && o_reqno == 12, "R6 other done", {o_done, o_reqno}, {1'b1, 8'd12});
    end

    // R8: illegal size
    idle();
    enq(0, 32'h600, 8'd4, 5'd3, 6'd0);
    rb_valid0 = 1; rb_addr0 = 32'h600; rb_reqno0 = 4; rb_data0 = '1;
    run_cycle(); enq_valid = 0;
    run_cycle(); run_cycle();
    chk(o_err && !o_wb, "R8 illegal size", {o_err, o_wb}, 2'b10);

    // R10/R9: fill, drop while full, drain in order
    idle();
    for (int k = 0; k < 8; k++) begin
      enq(3, 32'h700 + 32'(k), 8'(k), 5'd4, 6'd10);
      run_cycle();
    end
    enq(3, 32'h7ff, 8'd99, 5'd4, 6'd0);
    run_cycle();
    chk(full, "R10 full after eight", full, 1);
    enq_valid = 0;
    begin
      int nxt = 0;
      for (int k = 0; k < 40; k++) begin
        run_cycle();
        if (o_done) begin
          chk(o_reqno == 8'(nxt), "R9 drain order", o_reqno, nxt);
          nxt++;
        end
      end
      chk(nxt == 8, "R10 dropped enqueue", nxt, 8);
    end

    // random traffic
    for (int c = 0; c < 4000; c++) begin
      int pick;
      idle();
      if ($urandom_range(9) < 4) begin
        logic [4:0] sz;
        case ($urandom_range(5)) 0: sz = 1; 1: sz = 2; 2: sz = 4; 3: sz = 8; 4: sz = 16; default: sz = 3; endcase
        enq(2'($urandom_range(3)), 32'h1000 + 32'($urandom_range(3)) * 64, 8'($urandom_range(3)),
            sz, 6'($urandom_range(4)));
        enq_fp = 1'($urandom); enq_reg = 6'($urandom);
      end
      if ($urandom_range(1) == 1) begin
        pick = (mn > 0) ? int'($urandom_range(mn - 1)) : 0;
        rb_valid0 = 1; rb_addr0 = (mn > 0) ? ma[pick] : 32'h1000; rb_reqno0 = (mn > 0) ? mq[pick] : 0;
        rb_data0 = {$urandom, $urandom, $urandom, $urandom};
      end
      if ($urandom_range(1) == 1) begin
        pick = (mn > 0) ? int'($urandom_range(mn - 1)) : 0;
        rb_valid1 = 1; rb_addr1 = (mn > 0) ? ma[pick] : 32'h1040; rb_reqno1 = (mn > 0) ? mq[pick] : 1;
        rb_data1 = {$urandom, $urandom, $urandom, $urandom};
      end
      if ($urandom_range(2) == 0) begin
        pick = (mn > 0) ? int'($urandom_range(mn - 1)) : 0;
        fd_valid0 = 1; fd_addr0 = (mn > 0) ? ma[pick] : 0; fd_reqno0 = (mn > 0) ? mq[pick] : 0;
      end
      if ($urandom_range(2) == 0) begin
        pick = (mn > 0) ? int'($urandom_range(mn - 1)) : 0;
        fd_valid1 = 1; fd_addr1 = (mn > 0) ? ma[pick] : 0; fd_reqno1 = (mn > 0) ? mq[pick] : 0;
      end
      run_cycle();
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule